// File: doc/BRIEF.md
# Extended-Precision Memory Transfer Sequencer

This block moves one 80-bit extended-precision value between an internal register image and a big-endian, byte-addressed memory bus. In memory the value takes twelve bytes: a sign/exponent halfword, a pad halfword, then the mantissa as two 32-bit words, high word first. A one-cycle start pulse selects the direction (load from memory or store to memory), the address-register update rule and the incoming address-register value. The block then runs a short series of 16-bit and 32-bit bus transactions. Each transaction is held on the bus until it is acknowledged.

When the last transaction is acknowledged, the block raises a one-cycle done pulse. With done it presents the address-register value the caller must write back and, for a load, the assembled 80-bit value. An unsupported address-update code is rejected at once with an error pulse.

Top module: `xp_mem_sequencer`

## Requirements
- R1: A store issues exactly four write transactions, in this order: a 16-bit write at base+0 carrying the sign/exponent, a 16-bit write at base+2, a 32-bit write at base+4 carrying mantissa[63:32], and a 32-bit write at base+8 carrying mantissa[31:0]. `bus_size32` is 1 for a 32-bit transaction and 0 for a 16-bit one. 16-bit write data sits in `bus_wdata[15:0]`, with bits [31:16] zero. The store value is {sign/exponent[79:64], mantissa[63:0]}.
- R2: The 16-bit write at base+2 always carries zero data.
- R3: A load issues exactly three read transactions, in this order: a 16-bit read at base+0, a 32-bit read at base+4 and a 32-bit read at base+8. Address base+2 is never read.
- R4: A load assembles the value as {rdata[15:0] of the first read, rdata of the second read, rdata of the third read}. Bits [31:16] of the first read are ignored. `load_val` shows this value only while `done` is high and is zero at all other times.
- R5: With mode code 2'b01 (post-adjust), all accesses use the incoming address as base, and the reported address is the incoming address plus 12.
- R6: With mode code 2'b10 (pre-adjust), the base is the incoming address minus 12, and the reported address is that same reduced value.
- R7: With mode code 2'b00 (plain), the base is the incoming address, and the reported address equals the incoming address. `areg_out` is zero while `done` is low.
- R8: While `bus_req` is high and `bus_ack` is low, the request, address, direction, size and write data hold their values. A new transaction starts on the cycle after an acknowledge.
- R9: `done` rises exactly one cycle after the clock edge that takes the final acknowledge, and it lasts one cycle.
- R10: A start pulse that arrives while a transfer is in progress has no effect on the current transfer and does not begin a new one.
- R11: Mode code 2'b11 raises `err` for one cycle, on the cycle after start. It issues no bus transaction and raises no `done`.
- R12: After reset, `bus_req`, `done`, `err`, `load_val` and `areg_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a transfer |
| dir_store | input | 1 | 1 = store register to memory, 0 = load from memory |
| mode | input | 2 | Address update: 00 plain, 01 post-adjust, 10 pre-adjust, 11 invalid |
| areg_in | input | 32 | Incoming address-register value |
| store_val | input | 80 | Value to store: {sign/exponent, mantissa} |
| bus_req | output | 1 | Transaction request, held until acknowledged |
| bus_we | output | 1 | 1 = write transaction |
| bus_size32 | output | 1 | 1 = 32-bit transaction, 0 = 16-bit |
| bus_addr | output | 32 | Byte address of the transaction |
| bus_wdata | output | 32 | Write data (16-bit data in bits [15:0]) |
| bus_ack | input | 1 | Transaction completes in this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse for an invalid mode |
| areg_out | output | 32 | Updated address-register value, valid with done |
| load_val | output | 80 | Assembled loaded value, valid with done on a load |

## Verification
The first transaction appears on the bus one cycle after the start pulse, and each later transaction appears on the cycle after the previous acknowledge. `done`, `areg_out` and `load_val` are due one cycle after the final acknowledge. `err` is due one cycle after start. The bench's bus responder inserts a chosen number of wait cycles and logs every acknowledged transaction, together with the cycle number of the last acknowledge. The bench samples on the falling edge and requires `done` to appear exactly one counted cycle after that acknowledge, and to be gone on the following cycle. It also compares the `err` pulse and the logged transactions with values worked out from the incoming address and mode.

// File: rtl/xp_pkg.sv
package xp_pkg;
    localparam int EXP_W   = 16;
    localparam int MAN_W   = 64;
    localparam int VAL_W   = EXP_W + MAN_W;
    localparam int DW      = 32;
    localparam int OFF_W   = 4;
    // byte offsets of the fields inside the 12-byte image
    localparam int OFF_PAD = EXP_W / 8;
    localparam int OFF_MHI = 2 * (EXP_W / 8);
    localparam int OFF_MLO = OFF_MHI + DW / 8;
    localparam int IMG_BYTES = OFF_MLO + DW / 8;

    localparam logic [1:0] AM_PLAIN = 2'b00;
    localparam logic [1:0] AM_POST  = 2'b01;
    localparam logic [1:0] AM_PRE   = 2'b10;

    typedef enum logic {S_IDLE, S_BUS} seq_state_t;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic             wide;
        logic [DW-1:0]    wdata;
        logic             last;
    } beat_t;
endpackage

// File: rtl/xp_addr_unit.sv
module xp_addr_unit
    import xp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] areg,
    input  logic [1:0]    mode,
    output logic [AW-1:0] base,
    output logic [AW-1:0] areg_next,
    output logic          mode_ok
);
    localparam logic [AW-1:0] STEP = AW'(IMG_BYTES);

    always_comb begin
        base      = areg;
        areg_next = areg;
        mode_ok   = 1'b1;
        unique case (mode)
            AM_PLAIN: ;
            AM_POST:  areg_next = areg + STEP;
            AM_PRE: begin
                base      = areg - STEP;
                areg_next = areg - STEP;
            end
            default:  mode_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/xp_beat_plan.sv
module xp_beat_plan
    import xp_pkg::*;
(
    input  logic             is_store,
    input  logic [1:0]       idx,
    input  logic [VAL_W-1:0] value,
    output beat_t            beat
);
    logic [1:0] step;

    // loads skip the pad step: 0 -> 0, 1 -> 2, 2 -> 3
    always_comb begin
        if (is_store || idx == 2'd0) step = idx;
        else                          step = idx + 2'd1;
    end

    always_comb begin
        beat = '0;
        unique case (step)
            2'd0: begin
                beat.off   = OFF_W'(0);
                beat.wdata = DW'(value[VAL_W-1 -: EXP_W]);
            end
            2'd1: begin
                beat.off   = OFF_W'(OFF_PAD);
                beat.wdata = '0;
            end
            2'd2: begin
                beat.off   = OFF_W'(OFF_MHI);
                beat.wide  = 1'b1;
                beat.wdata = value[MAN_W-1 -: DW];
            end
            default: begin
                beat.off   = OFF_W'(OFF_MLO);
                beat.wide  = 1'b1;
                beat.wdata = value[DW-1:0];
                beat.last  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/xp_mem_sequencer.sv
module xp_mem_sequencer
    import xp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_store,
    input  logic [1:0]       mode,
    input  logic [AW-1:0]    areg_in,
    input  logic [VAL_W-1:0] store_val,
    output logic             bus_req,
    output logic             bus_we,
    output logic             bus_size32,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic             bus_ack,
    input  logic [DW-1:0]    bus_rdata,
    output logic             done,
    output logic             err,
    output logic [AW-1:0]    areg_out,
    output logic [VAL_W-1:0] load_val
);
    typedef struct packed {
        seq_state_t       st;
        logic             store;
        logic [1:0]       idx;
        logic [AW-1:0]    base;
        logic [AW-1:0]    nareg;
        logic [VAL_W-1:0] val;
        logic             done;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0] base_w, nareg_w;
    logic          mode_ok_w;
    beat_t         beat_w;
    logic          busy_w;

    xp_addr_unit #(.AW(AW)) u_addr (
        .areg      (areg_in),
        .mode      (mode),
        .base      (base_w),
        .areg_next (nareg_w),
        .mode_ok   (mode_ok_w)
    );

    xp_beat_plan u_plan (
        .is_store (r_q.store),
        .idx      (r_q.idx),
        .value    (r_q.val),
        .beat     (beat_w)
    );

    assign busy_w = (r_q.st == S_BUS);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    if (!mode_ok_w) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st    = S_BUS;
                        r_d.store = dir_store;
                        r_d.idx   = 2'd0;
                        r_d.base  = base_w;
                        r_d.nareg = nareg_w;
                        r_d.val   = dir_store ? store_val : '0;
                    end
                end
            end
            default: begin
                if (bus_ack) begin
                    if (!r_q.store) begin
                        unique case (r_q.idx)
                            2'd0:    r_d.val[VAL_W-1 -: EXP_W] = bus_rdata[EXP_W-1:0];
                            2'd1:    r_d.val[MAN_W-1 -: DW]    = bus_rdata;
                            default: r_d.val[DW-1:0]           = bus_rdata;
                        endcase
                    end
                    if (beat_w.last) begin
                        r_d.st   = S_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + 2'd1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_req    = busy_w;
    assign bus_we     = busy_w && r_q.store;
    assign bus_size32 = busy_w && beat_w.wide;
    assign bus_addr   = busy_w ? (r_q.base + AW'(beat_w.off)) : '0;
    assign bus_wdata  = (busy_w && r_q.store) ? beat_w.wdata : '0;
    assign done       = r_q.done;
    assign err        = r_q.err;
    assign areg_out   = r_q.done ? r_q.nareg : '0;
    assign load_val   = (r_q.done && !r_q.store) ? r_q.val : '0;

    // R8: a pending transaction is held until acknowledged
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                                && $stable(bus_size32) && $stable(bus_wdata));

    // R2: the pad halfword is written as zero
    p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == r_q.base + AW'(OFF_PAD) |-> bus_wdata == '0);

    // R3: a load never touches the pad halfword
    p_no_pad_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_we |-> bus_addr != r_q.base + AW'(OFF_PAD));

    // R11: a rejected request leaves the bus idle
    p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !bus_req && !done);

    // R9: done is a single-cycle pulse following an acknowledge
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_req && bus_ack));

    // R4: no loaded value leaks outside the done cycle
    p_loadval_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> load_val == '0);
endmodule

// File: tb/tb_xp_mem_sequencer.sv
`timescale 1ns/1ps
module tb_xp_mem_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_store = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [31:0] areg_in = '0;
    logic [79:0] store_val = '0;
    logic        bus_req, bus_we, bus_size32;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        done, err;
    logic [31:0] areg_out;
    logic [79:0] load_val;

    always #4 clk = ~clk;

    xp_mem_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_store(dir_store),
        .mode(mode), .areg_in(areg_in), .store_val(store_val),
        .bus_req(bus_req), .bus_we(bus_we), .bus_size32(bus_size32),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .done(done), .err(err),
        .areg_out(areg_out), .load_val(load_val)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ack_cyc = 0;
    int waits_cfg = 0;
    int wc = 0;
    int hold_bad = 0;
    bit waiting = 0;
    logic [31:0] p_addr, p_wdata;
    logic p_we, p_sz;
    logic [7:0] mem [0:255];
    int ntx = 0;
    logic [31:0] t_addr [0:7];
    logic [31:0] t_wd [0:7];
    logic        t_we [0:7];
    logic        t_sz [0:7];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus responder: acknowledges after waits_cfg idle cycles, logs transactions
    always @(negedge clk) begin
        bus_ack = 1'b0;
        if (rst_n && bus_req) begin
            if (wc >= waits_cfg) begin
                bus_ack = 1'b1;
                wc = 0;
                waiting = 0;
                ack_cyc = cyc;
                if (ntx < 8) begin
                    t_addr[ntx] = bus_addr; t_wd[ntx] = bus_wdata;
                    t_we[ntx] = bus_we;     t_sz[ntx] = bus_size32;
                end
                ntx++;
                if (bus_we) begin
                    if (bus_size32) begin
                        mem[bus_addr[7:0]]       = bus_wdata[31:24];
                        mem[bus_addr[7:0] + 8'd1] = bus_wdata[23:16];
                        mem[bus_addr[7:0] + 8'd2] = bus_wdata[15:8];
                        mem[bus_addr[7:0] + 8'd3] = bus_wdata[7:0];
                    end else begin
                        mem[bus_addr[7:0]]       = bus_wdata[15:8];
                        mem[bus_addr[7:0] + 8'd1] = bus_wdata[7:0];
                    end
                end else if (bus_size32) begin
                    bus_rdata = {mem[bus_addr[7:0]], mem[bus_addr[7:0] + 8'd1],
                                 mem[bus_addr[7:0] + 8'd2], mem[bus_addr[7:0] + 8'd3]};
                end else begin
                    bus_rdata = {16'hDEAD, mem[bus_addr[7:0]], mem[bus_addr[7:0] + 8'd1]};
                end
            end else begin
                if (waiting && (bus_addr !== p_addr || bus_wdata !== p_wdata ||
                                bus_we !== p_we || bus_sz_chg(p_sz)))
                    hold_bad++;
                p_addr = bus_addr; p_wdata = bus_wdata; p_we = bus_we; p_sz = bus_size32;
                waiting = 1;
                wc++;
            end
        end
    end

    function automatic bit bus_sz_chg(input logic prev);
        return bus_size32 !== prev;
    endfunction

    task automatic launch(input bit st, input logic [1:0] md, input logic [31:0] a, input logic [79:0] v);
        @(negedge clk);
        ntx = 0;
        start = 1'b1; dir_store = st; mode = md; areg_in = a; store_val = v;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req, output bit seen);
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, req, 80'(seen), 80'd1);
    endtask

    task automatic test_store(input logic [1:0] md, input logic [31:0] a, input logic [79:0] v,
                              input int waits, input logic [31:0] base, input logic [31:0] na,
                              input string areq);
        bit seen;
        waits_cfg = waits;
        for (int i = 0; i < 12; i++) mem[base[7:0] + 8'(i)] = 8'h55;
        launch(1'b1, md, a, v);
        wait_done("R9 store done", seen);
        if (!seen) return;
        chk(cyc == ack_cyc + 1, "R9 done one cycle after last ack", 80'(cyc), 80'(ack_cyc + 1));
        chk(areg_out == na, areq, 80'(areg_out), 80'(na));
        chk(ntx == 4, "R1 store transaction count", 80'(ntx), 80'd4);
        chk(t_addr[0] == base && t_addr[1] == base + 2 && t_addr[2] == base + 4 && t_addr[3] == base + 8,
            "R1 store addresses", 80'(t_addr[3]), 80'(base + 8));
        chk(!t_sz[0] && !t_sz[1] && t_sz[2] && t_sz[3] && t_we[0] && t_we[1] && t_we[2] && t_we[3],
            "R1 store sizes/direction", {76'd0, t_sz[0], t_sz[1], t_sz[2], t_sz[3]}, 80'h3);
        chk(t_wd[0] == {16'h0, v[79:64]} && t_wd[2] == v[63:32] && t_wd[3] == v[31:0],
            "R1 store data", {t_wd[0][15:0], t_wd[2], t_wd[3]}, v);
        chk(t_wd[1] == 32'h0 && mem[base[7:0] + 8'd2] == 8'h0 && mem[base[7:0] + 8'd3] == 8'h0,
            "R2 pad written as zero", 80'(t_wd[1]), 80'd0);
        chk(load_val == '0, "R4 no load value after store", load_val, 80'd0);
        @(negedge clk);
        chk(!done && !bus_req, "R9 single-cycle done", 80'(done), 80'd0);
    endtask

    task automatic test_load(input logic [1:0] md, input logic [31:0] a, input logic [79:0] v,
                             input int waits, input logic [31:0] base, input logic [31:0] na,
                             input string areq);
        bit seen;
        waits_cfg = waits;
        mem[base[7:0]]       = v[79:72];
        mem[base[7:0] + 8'd1] = v[71:64];
        mem[base[7:0] + 8'd2] = 8'hAA;
        mem[base[7:0] + 8'd3] = 8'hBB;
        for (int i = 0; i < 8; i++) mem[base[7:0] + 8'(4 + i)] = v[63 - 8*i -: 8];
        launch(1'b0, md, a, '1);
        chk(load_val == '0 && areg_out == '0, "R4 outputs hidden before done", load_val, 80'd0);
        wait_done("R9 load done", seen);
        if (!seen) return;
        chk(cyc == ack_cyc + 1, "R9 done one cycle after last ack", 80'(cyc), 80'(ack_cyc + 1));
        chk(load_val == v, "R4 assembled load value", load_val, v);
        chk(areg_out == na, areq, 80'(areg_out), 80'(na));
        chk(ntx == 3, "R3 load transaction count", 80'(ntx), 80'd3);
        chk(t_addr[0] == base && t_addr[1] == base + 4 && t_addr[2] == base + 8 &&
            !t_sz[0] && t_sz[1] && t_sz[2] && !t_we[0] && !t_we[1] && !t_we[2],
            "R3 load addresses/sizes", 80'(t_addr[1]), 80'(base + 4));
        @(negedge clk);
        chk(!done && load_val == '0, "R4 value gone after done", load_val, 80'd0);
    endtask

    task automatic test_invalid();
        launch(1'b1, 2'b11, 32'h0000_0060, 80'h1234);
        chk(err == 1'b1, "R11 err one cycle after start", 80'(err), 80'd1);
        chk(!bus_req && !done, "R11 no bus activity", 80'(bus_req), 80'd0);
        @(negedge clk);
        chk(!err && ntx == 0 && !bus_req && !done, "R11 err pulse ends, no transactions",
            80'(ntx), 80'd0);
    endtask

    task automatic test_busy_start();
        bit seen;
        logic [79:0] v = 80'h4001_C000_0000_0000_0001;
        waits_cfg = 2;
        launch(1'b1, 2'b01, 32'h0000_0040, v);
        @(negedge clk);
        start = 1'b1; dir_store = 1'b0; mode = 2'b10; areg_in = 32'h0000_00A0; store_val = '0;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10 done", seen);
        if (!seen) return;
        chk(ntx == 4 && t_addr[0] == 32'h40 && t_wd[3] == v[31:0], "R10 busy start ignored",
            80'(t_addr[0]), 80'h40);
        chk(areg_out == 32'h4C, "R10 address unaffected", 80'(areg_out), 80'h4C);
        chk(hold_bad == 0, "R8 hold while waiting", 80'(hold_bad), 80'd0);
        @(negedge clk);
        chk(!bus_req && !done && ntx == 4, "R10 no second transfer", 80'(bus_req), 80'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!bus_req && !done && !err && load_val == '0 && areg_out == '0,
            "R12 reset state", {bus_req, done, err}, 80'd0);
        rst_n = 1'b1;
        @(negedge clk);
        test_store(2'b00, 32'h0001_0020, 80'hBFFF_8000_0000_1234_5678, 0, 32'h0001_0020, 32'h0001_0020, "R7 plain address kept");
        test_store(2'b01, 32'h0000_0040, 80'h3FFE_ABCD_EF01_2345_6789, 1, 32'h0000_0040, 32'h0000_004C, "R5 post-adjust +12");
        test_store(2'b10, 32'h0000_008C, 80'h7FFF_8000_0000_0000_0000, 3, 32'h0000_0080, 32'h0000_0080, "R6 pre-adjust -12");
        test_load(2'b00, 32'h0002_0010, 80'hC00A_F0E1_D2C3_B4A5_9687, 0, 32'h0002_0010, 32'h0002_0010, "R7 plain address kept");
        test_load(2'b01, 32'h0000_00B0, 80'h0000_0000_0000_0000_0001, 2, 32'h0000_00B0, 32'h0000_00BC, "R5 post-adjust +12");
        test_load(2'b10, 32'h0000_00DC, 80'h8001_FFFF_FFFF_FFFF_FFFF, 1, 32'h0000_00D0, 32'h0000_00D0, "R6 pre-adjust -12");
        test_invalid();
        test_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule